// File: doc/BRIEF.md
# Tiny Accumulator CPU

A minimal stored-program machine with a 32-bit accumulator. It has an internal store of 32 words of 32 bits. Each word can serve as data or as an instruction. The machine holds three architectural registers: the accumulator, a 5-bit counter that points at the current instruction, and a present-instruction register that holds the decoded opcode and address. There are no I/O devices and no interrupts. A program is deposited through the debug port while the machine is halted. A `start` pulse sets it running, and it runs until it executes a stop instruction or meets an enabled breakpoint.

Every instruction passes through three states of a small sequencer:

- **S_FETCH** checks the breakpoint and then pre-increments the counter.
- **S_DECODE** reads the store at the new counter value and latches the opcode and address fields.
- **S_EXEC** reads the operand word, updates the accumulator, the counter or the store, and then returns to S_FETCH.

A fourth state, **S_HALT**, is entered from reset, from S_EXEC on a stop opcode, and from S_FETCH on a breakpoint hit. The transitions are:

- S_HALT to S_FETCH on `start`.
- S_FETCH to S_HALT on a breakpoint hit; otherwise S_FETCH to S_DECODE.
- S_DECODE to S_EXEC, always.
- S_EXEC to S_HALT on a stop opcode; otherwise S_EXEC to S_FETCH.

While the machine is in S_HALT, the debug port writes store words and reads them back combinationally. The accumulator and the counter are always visible on read-only outputs.

Top module: `accum_cpu`

## Requirements
- R1: After reset the machine is halted (`halted`=1), and the counter and the accumulator both read 0.
- R2: An instruction word carries its opcode in bits 15:13 and its store address in bits 4:0. Bits 31:16 and 12:5 have no effect on execution.
- R3: Each instruction begins by incrementing the counter modulo 32. The instruction is then read from the store at the new value, so after reset the first instruction executed is word 1, and counter 31 wraps to word 0.
- R4: Opcode 0 sets the counter to bits 4:0 of the addressed store word.
- R5: Opcode 1 adds bits 4:0 of the addressed store word to the counter, modulo 32.
- R6: Opcode 2 sets the accumulator to the two's-complement negation of the addressed word.
- R7: Opcode 3 writes the accumulator into the addressed store word.
- R8: Opcodes 4 and 5 both subtract the addressed word from the accumulator, modulo 2^32.
- R9: Opcode 6 ignores its address field. It adds one to the counter, skipping the next instruction, exactly when accumulator bit 31 is set.
- R10: Opcode 7 halts the machine. Every instruction takes three clock cycles. If a run executes k instructions and ends on opcode 7, `halted` reads 1 exactly 3k rising edges after the edge that accepts `start`.
- R11: With `bkpt_en`=1, the machine halts in S_FETCH, before the increment, when `bkpt_addr` equals the counter. The counter is left unchanged, and `halted` reads 1 after 3k+1 edges. The first S_FETCH after each `start` does not check the breakpoint, so the run resumes past it.
- R12: Debug writes (`dbg_we`) take effect only while halted and are ignored while the machine runs. `dbg_rdata` shows the store word at `dbg_addr` while halted. `start` has no effect while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Leave S_HALT and begin running |
| halted | output | 1 | Machine is in S_HALT |
| bkpt_en | input | 1 | Breakpoint compare enable |
| bkpt_addr | input | 5 | Counter value that triggers the breakpoint |
| dbg_we | input | 1 | Debug store write strobe, honoured only while halted |
| dbg_addr | input | 5 | Debug store address |
| dbg_wdata | input | 32 | Debug store write data |
| dbg_rdata | output | 32 | Store word at `dbg_addr` while halted |
| dbg_acc | output | 32 | Current accumulator value |
| dbg_ctr | output | 5 | Current counter value |

## Verification
Random 32-word images, with random bits in every field, run against a bench interpreter. Any decoder that looked at ignored bits, or that mishandled the aliased subtract, would diverge in the store image or the accumulator. Directed programs cover the following cases, each of which fails if the design gets it wrong:

- A jump that lands on 31, followed by the pre-increment wrap to word 0. A design that fetched before incrementing, or that kept more than five counter bits, would run the wrong word.
- A relative jump taken from counter 0.
- The skip taken and not taken. A design that tested the wrong sign would stop one word early or late.
- A breakpoint stop and the resume past it. A design that checked the breakpoint after the increment, or on the resuming fetch, would halt at the wrong counter, or would never make progress after resuming.
- A debug write issued while a loop runs. It must leave the target word intact.

// File: rtl/acm_pkg.sv
package acm_pkg;

    parameter int ACM_ADDR_W = 5;
    parameter int ACM_DATA_W = 32;
    parameter int ACM_OP_LSB = 13;

    typedef enum logic [2:0] {
        OP_JMP  = 3'd0,
        OP_JRP  = 3'd1,
        OP_LDN  = 3'd2,
        OP_STO  = 3'd3,
        OP_SUB  = 3'd4,
        OP_SUBX = 3'd5,
        OP_SKN  = 3'd6,
        OP_HLT  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        S_HALT   = 2'd0,
        S_FETCH  = 2'd1,
        S_DECODE = 2'd2,
        S_EXEC   = 2'd3
    } state_e;

endpackage

// File: rtl/acm_store.sv
module acm_store #(
    parameter int ADDR_W = acm_pkg::ACM_ADDR_W,
    parameter int DATA_W = acm_pkg::ACM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

    // R7 / R12: a granted write is visible at its address on the next cycle
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> words[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/acm_seq.sv
module acm_seq
    import acm_pkg::*;
#(
    parameter int ADDR_W = ACM_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bkpt_en,
    input  logic [ADDR_W-1:0] bkpt_addr,
    input  logic [ADDR_W-1:0] ctr,
    input  op_e               op,
    output state_e            state,
    output logic              halted,
    output logic              fetch_go,
    output logic              decode_en,
    output logic              exec_en
);
    state_e state_q, state_d;
    logic   skip_q;
    logic   bp_hit;

    assign bp_hit = bkpt_en && (bkpt_addr == ctr) && !skip_q;

    // state register and the one-shot breakpoint bypass flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HALT;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_HALT && start) begin
                skip_q <= 1'b1;
            end else if (state_q == S_FETCH) begin
                skip_q <= 1'b0;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HALT:   if (start) state_d = S_FETCH;
            S_FETCH:  state_d = bp_hit ? S_HALT : S_DECODE;
            S_DECODE: state_d = S_EXEC;
            S_EXEC:   state_d = (op == OP_HLT) ? S_HALT : S_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        halted    = 1'b0;
        fetch_go  = 1'b0;
        decode_en = 1'b0;
        exec_en   = 1'b0;
        unique case (state_q)
            S_HALT:   halted    = 1'b1;
            S_FETCH:  fetch_go  = !bp_hit;
            S_DECODE: decode_en = 1'b1;
            S_EXEC:   exec_en   = 1'b1;
        endcase
    end

    assign state = state_q;

    // R10: a stop opcode in execute halts on the next cycle
    p_stop_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_HLT) |=> halted);

    // R10: decode is always followed by execute
    p_decode_then_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        decode_en |=> exec_en);

    // R11: a breakpoint hit halts without moving the counter
    p_bkpt_holds_ctr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && bp_hit) |=> (halted && $stable(ctr)));

    // R11: the fetch that follows a start never stops on the breakpoint
    p_resume_passes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && start) |=> ##1 decode_en);

endmodule

// File: rtl/acm_datapath.sv
module acm_datapath
    import acm_pkg::*;
#(
    parameter int ADDR_W = ACM_ADDR_W,
    parameter int DATA_W = ACM_DATA_W,
    parameter int OP_LSB = ACM_OP_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_go,
    input  logic              decode_en,
    input  logic              exec_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ctr,
    output logic [DATA_W-1:0] acc,
    output op_e               op,
    output logic [ADDR_W-1:0] opnd_addr,
    output logic              st_we,
    output logic [DATA_W-1:0] st_wdata
);
    localparam int OP_MSB = OP_LSB + 2;

    logic [ADDR_W-1:0] ctr_q;
    logic [DATA_W-1:0] acc_q;
    op_e               pir_op_q;
    logic [ADDR_W-1:0] pir_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q      <= '0;
            acc_q      <= '0;
            pir_op_q   <= OP_JMP;
            pir_addr_q <= '0;
        end else begin
            if (fetch_go) begin
                ctr_q <= ctr_q + 1'b1;
            end
            if (decode_en) begin
                pir_op_q   <= op_e'(rd_data[OP_MSB:OP_LSB]);
                pir_addr_q <= rd_data[ADDR_W-1:0];
            end
            if (exec_en) begin
                unique case (pir_op_q)
                    OP_JMP:          ctr_q <= rd_data[ADDR_W-1:0];
                    OP_JRP:          ctr_q <= ctr_q + rd_data[ADDR_W-1:0];
                    OP_LDN:          acc_q <= '0 - rd_data;
                    OP_STO:          ;
                    OP_SUB, OP_SUBX: acc_q <= acc_q - rd_data;
                    OP_SKN:          if (acc_q[DATA_W-1]) ctr_q <= ctr_q + 1'b1;
                    OP_HLT:          ;
                endcase
            end
        end
    end

    assign ctr       = ctr_q;
    assign acc       = acc_q;
    assign op        = pir_op_q;
    assign opnd_addr = pir_addr_q;
    assign st_we     = exec_en && (pir_op_q == OP_STO);
    assign st_wdata  = acc_q;

    // R3: fetch advances the counter by one, modulo the store size
    p_preinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> ctr_q == ADDR_W'($past(ctr_q) + 1'b1));

    // R6: load negated
    p_load_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && pir_op_q == OP_LDN) |=> acc_q == DATA_W'(0 - $past(rd_data)));

    // R8: both subtract encodings
    p_subtract_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (pir_op_q == OP_SUB || pir_op_q == OP_SUBX))
        |=> acc_q == DATA_W'($past(acc_q) - $past(rd_data)));

    // R9: skip taken when negative
    p_skip_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && pir_op_q == OP_SKN && acc_q[DATA_W-1])
        |=> ctr_q == ADDR_W'($past(ctr_q) + 1'b1));

    // R9: no skip when not negative
    p_skip_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && pir_op_q == OP_SKN && !acc_q[DATA_W-1]) |=> $stable(ctr_q));

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
    import acm_pkg::*;
#(
    parameter int ADDR_W = ACM_ADDR_W,
    parameter int DATA_W = ACM_DATA_W,
    parameter int OP_LSB = ACM_OP_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              halted,
    input  logic              bkpt_en,
    input  logic [ADDR_W-1:0] bkpt_addr,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic [DATA_W-1:0] dbg_acc,
    output logic [ADDR_W-1:0] dbg_ctr
);
    state_e            state;
    logic              fetch_go, decode_en, exec_en;
    logic [ADDR_W-1:0] ctr, opnd_addr;
    logic [DATA_W-1:0] acc, rd_data, dp_wdata;
    op_e               op;
    logic              dp_we;

    logic              st_we;
    logic [ADDR_W-1:0] st_waddr, st_raddr;
    logic [DATA_W-1:0] st_wdata;

    acm_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bkpt_en   (bkpt_en),
        .bkpt_addr (bkpt_addr),
        .ctr       (ctr),
        .op        (op),
        .state     (state),
        .halted    (halted),
        .fetch_go  (fetch_go),
        .decode_en (decode_en),
        .exec_en   (exec_en)
    );

    acm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_LSB(OP_LSB)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_go  (fetch_go),
        .decode_en (decode_en),
        .exec_en   (exec_en),
        .rd_data   (rd_data),
        .ctr       (ctr),
        .acc       (acc),
        .op        (op),
        .opnd_addr (opnd_addr),
        .st_we     (dp_we),
        .st_wdata  (dp_wdata)
    );

    // store port arbitration: execute owns it while running, debug while halted
    always_comb begin
        unique case (state)
            S_DECODE: st_raddr = ctr;
            S_EXEC:   st_raddr = opnd_addr;
            default:  st_raddr = dbg_addr;
        endcase
    end

    assign st_we    = dp_we || (halted && dbg_we);
    assign st_waddr = dp_we ? opnd_addr : dbg_addr;
    assign st_wdata = dp_we ? dp_wdata  : dbg_wdata;

    acm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (st_raddr),
        .rdata (rd_data)
    );

    assign dbg_rdata = rd_data;
    assign dbg_acc   = acc;
    assign dbg_ctr   = ctr;

    // R12: sitting halted (with or without debug traffic) changes no register
    p_halt_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> ($stable(acc) && $stable(ctr)));

endmodule

// File: tb/accum_cpu_test.sv
module accum_cpu_test;
    localparam int CLK_PERIOD = 10;
    localparam int MODEL_LIMIT = 200;
    localparam int N_RANDOM = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        halted;
    logic        bkpt_en = 1'b0;
    logic [4:0]  bkpt_addr = '0;
    logic        dbg_we = 1'b0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [31:0] dbg_acc;
    logic [4:0]  dbg_ctr;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] img   [32];
    logic [31:0] m_mem [32];
    logic [31:0] m_acc;
    logic [4:0]  m_ctr;
    logic        m_bp_en;
    logic [4:0]  m_bp;
    bit          m_bp_stop;

    always #(CLK_PERIOD / 2) clk = ~clk;

    accum_cpu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .halted(halted),
        .bkpt_en(bkpt_en), .bkpt_addr(bkpt_addr),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .dbg_acc(dbg_acc), .dbg_ctr(dbg_ctr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int a, input logic [31:0] junk);
        return (junk & 32'hFFFF_1FE0) | (32'(op) << 13) | 32'(a & 31);
    endfunction

    // bench interpreter of the requirements
    task automatic model_run(input bit skip_first, output int k, output bit ok);
        logic [31:0] ir, d;
        logic [2:0]  op;
        logic [4:0]  a;
        k = 0;
        ok = 1'b0;
        for (int n = 0; n < MODEL_LIMIT; n++) begin
            if (m_bp_en && m_bp == m_ctr && !skip_first) begin
                ok = 1'b1; m_bp_stop = 1'b1; return;
            end
            skip_first = 1'b0;
            m_ctr = m_ctr + 5'd1;
            ir = m_mem[m_ctr];
            op = ir[15:13];
            a  = ir[4:0];
            d  = m_mem[a];
            k++;
            case (op)
                3'd0: m_ctr = d[4:0];
                3'd1: m_ctr = m_ctr + d[4:0];
                3'd2: m_acc = 32'd0 - d;
                3'd3: m_mem[a] = m_acc;
                3'd4, 3'd5: m_acc = m_acc - d;
                3'd6: if (m_acc[31]) m_ctr = m_ctr + 5'd1;
                default: begin ok = 1'b1; m_bp_stop = 1'b0; return; end
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_acc = '0;
        m_ctr = '0;
    endtask

    task automatic load_image();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            dbg_we = 1'b1; dbg_addr = 5'(i); dbg_wdata = img[i];
        end
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic read_word(input int a, output logic [31:0] v);
        @(negedge clk);
        dbg_addr = 5'(a);
        #1 v = dbg_rdata;
    endtask

    task automatic hw_run(output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!halted && cyc < 2000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        cyc = cyc - 1;
    endtask

    task automatic compare(input string tag, input int k, input int cyc);
        logic [31:0] v;
        chk({tag, " R10 halted"}, 32'(halted), 32'd1);
        chk({tag, (m_bp_stop ? " R11 cycles" : " R10 cycles")}, 32'(cyc),
            m_bp_stop ? 32'(3 * k + 1) : 32'(3 * k));
        chk({tag, " R3 counter"}, 32'(dbg_ctr), 32'(m_ctr));
        chk({tag, " R6/R8 accumulator"}, dbg_acc, m_acc);
        for (int i = 0; i < 32; i++) begin
            read_word(i, v);
            chk({tag, " R7/R12 store word"}, v, m_mem[i]);
        end
    endtask

    task automatic run_program(input string tag, input bit be, input logic [4:0] ba);
        int k, cyc;
        bit ok;
        do_reset();
        m_mem = img;
        m_bp_en = be;
        m_bp = ba;
        model_run(1'b1, k, ok);
        load_image();
        bkpt_en = be;
        bkpt_addr = ba;
        hw_run(cyc);
        compare(tag, k, cyc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k, cyc, seed_dummy;
        bit ok;
        logic [31:0] v;
        seed_dummy = int'($urandom(32'd4242));

        // R1: reset state
        do_reset();
        #1;
        chk("R1 halted", 32'(halted), 32'd1);
        chk("R1 counter", 32'(dbg_ctr), 32'd0);
        chk("R1 accumulator", dbg_acc, 32'd0);

        // R2 R6 R7 R8: arithmetic, junk in the ignored bits, aliased subtract
        foreach (img[i]) img[i] = 32'(i) * 32'h0101_0101;
        img[1] = mk(2, 20, 32'hFFFF_FFFF);
        img[2] = mk(4, 21, 32'hA5A5_A5A5);
        img[3] = mk(5, 23, 32'h5A5A_5A5A);
        img[4] = mk(3, 22, 32'hFFFF_1FE0);
        img[5] = mk(7, 9, 32'h1234_5678);
        img[20] = 32'd5; img[21] = 32'd3; img[23] = 32'd2;
        run_program("R2 arith", 1'b0, 5'd0);
        read_word(22, v);
        chk("R7 stored value", v, 32'hFFFF_FFF6);
        chk("R8 aliased subtract", dbg_acc, 32'hFFFF_FFF6);

        // R3 R4 R5: jump to 31, wrap to word 0, relative jump
        foreach (img[i]) img[i] = mk(7, 0, 32'h0);
        img[1]  = mk(0, 10, 32'h0);
        img[10] = 32'hFFFF_FFFE;
        img[30] = mk(2, 11, 32'h0);
        img[31] = mk(0, 11, 32'hFFFF_0000);
        img[11] = 32'hFFFF_FFFF;
        img[0]  = mk(1, 12, 32'h0);
        img[12] = 32'h0000_0025;
        img[5]  = mk(2, 10, 32'h0);
        img[6]  = mk(7, 0, 32'h0);
        run_program("R4 wrap", 1'b0, 5'd0);
        chk("R5 relative jump target", 32'(dbg_ctr), 32'd6);

        // R9: skip taken
        foreach (img[i]) img[i] = mk(7, 0, 32'h0);
        img[1] = mk(2, 20, 32'h0);
        img[2] = mk(6, 17, 32'hFFFF_0000);
        img[4] = mk(2, 21, 32'h0);
        img[20] = 32'd1; img[21] = 32'd7;
        run_program("R9 skip taken", 1'b0, 5'd0);
        chk("R9 skip taken acc", dbg_acc, 32'hFFFF_FFF9);
        // R9: skip not taken
        img[20] = 32'd0;
        run_program("R9 skip idle", 1'b0, 5'd0);
        chk("R9 skip idle ctr", 32'(dbg_ctr), 32'd3);

        // R11: breakpoint stop, then resume past it
        foreach (img[i]) img[i] = mk(7, 0, 32'h0);
        img[1] = mk(2, 20, 32'h0);
        img[2] = mk(4, 21, 32'h0);
        img[3] = mk(3, 22, 32'h0);
        img[20] = 32'd9; img[21] = 32'd4;
        run_program("R11 bkpt", 1'b1, 5'd2);
        chk("R11 stop counter", 32'(dbg_ctr), 32'd2);
        model_run(1'b1, k, ok);
        hw_run(cyc);
        compare("R11 resume", k, cyc);

        // R12: debug write during a run is ignored; start ignored while running
        foreach (img[i]) img[i] = 32'h0;
        img[1]  = mk(0, 2, 32'h0);
        img[20] = 32'h1234_5678;
        do_reset();
        load_image();
        bkpt_en = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R12 running", 32'(halted), 32'd0);
        dbg_we = 1'b1; dbg_addr = 5'd20; dbg_wdata = 32'hDEAD_BEEF; start = 1'b1;
        repeat (4) @(negedge clk);
        dbg_we = 1'b0; start = 1'b0;
        chk("R12 start while running", 32'(halted), 32'd0);
        bkpt_en = 1'b1; bkpt_addr = 5'd0;
        repeat (10) @(negedge clk);
        chk("R11 loop stopped", 32'(halted), 32'd1);
        chk("R11 loop counter", 32'(dbg_ctr), 32'd0);
        read_word(20, v);
        chk("R12 write ignored", v, 32'h1234_5678);
        bkpt_en = 1'b0;

        // random images against the interpreter
        for (int p = 0; p < N_RANDOM; p++) begin
            logic       be;
            logic [4:0] ba;
            ok = 1'b0;
            for (int t = 0; t < 100 && !ok; t++) begin
                foreach (img[i]) img[i] = $urandom;
                be = 1'($urandom_range(0, 1));
                ba = 5'($urandom_range(0, 31));
                m_mem = img; m_acc = '0; m_ctr = '0;
                m_bp_en = be; m_bp = ba;
                model_run(1'b1, k, ok);
            end
            if (ok) run_program("R2/R4/R5/R6/R8/R9 random", be, ba);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule